// File: doc/BRIEF.md
# Removable Card Presence Interrupt Controller

This block watches the presence, write-protect and busy pins of a removable memory card slot. It raises an interrupt when a card is inserted or removed. All three pins pass through a synchronizer. Software reads the synchronized pin levels from a status register. Software enables card events through a global enable plus separate insert and remove enables. The hardware arms only the event that can happen next: the remove event while a card is in the slot, and the insert event while the slot is empty. A latched event stays set until software writes a one to its bit.

The same block collects the completion and error events of the card's DMA engine into a second event register, with its own enable mask, and drives one level-sensitive interrupt line for both sources. A cause register tells software which source to service first, and card events always rank above DMA events. When a card event is latched, the block clears every card and DMA interrupt enable in the same cycle. This keeps an unsettled slot from producing further interrupts until software has re-armed it. Register access is a plain single-cycle write strobe with an address, and the read data is combinational from the address. There is no streaming data path, so there is no valid/ready handshake.

Top module: `cdi_ctrl`

## Requirements
- R1: After reset, the card enable register (address 1), the card event register (address 2), the DMA enable register (address 3) and the DMA event register (address 4) all read zero, and irq is low.
- R2: The pin status register (address 0) reads bit0 = card present, bit1 = write protected, bit2 = busy, bit3 = ready (the inverse of busy). Each bit reflects its pin two clock edges after the pin changes.
- R3: A write to address 1 loads bit0 = global enable, bit1 = insert enable, bit2 = remove enable, and a read returns these bits.
- R4: Address 0 bit4 reads insert-armed (global and insert enable set and the card absent), and bit5 reads remove-armed (global and remove enable set and the card present).
- R5: A synchronized rising edge of presence sets card event bit0 (insert) only if insert was armed. A falling edge sets bit1 (remove) only if remove was armed. The bit is readable three clock edges after the pin changes. An edge that is not armed leaves the event register at zero.
- R6: In the cycle a card event is latched, the card enable register and the DMA enable register are both cleared to zero. Without an event, they keep their values.
- R7: Writing a one to a card event bit clears it, and writing a zero leaves it unchanged.
- R8: A pulse on dma_evt[i] sets DMA event bit i at address 4. Writing a one clears the bit. If the same bit is both set and cleared in one cycle, the set wins. Address 3 holds the DMA enable mask.
- R9: irq is high whenever any card event bit is set, or any DMA event bit is set together with its enable. It stays high until those bits are cleared or masked.
- R10: The cause register (address 5) reads 1 when any card event is pending. Otherwise it reads 2 when any enabled DMA event is pending, and otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_present | input | 1 | Asynchronous card presence pin, high when a card is in the slot |
| pin_wprot | input | 1 | Asynchronous write-protect pin |
| pin_busy | input | 1 | Asynchronous card busy pin |
| dma_evt | input | DMA_W | One-cycle DMA event pulses, one bit per event kind |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| irq | output | 1 | Level-sensitive combined interrupt |

## Verification
A pin change is due in the pin status register after two clock edges, and in the card event register, irq and the cleared enables after three. The bench drives each pin on a falling edge and waits three falling edges before it reads. Register writes and DMA pulses take effect at the next rising edge, so the bench reads them back at the falling edge that follows. The bench sweeps all eight card enable patterns against both edge directions, and all 64 pairs of DMA enable and DMA event pattern.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_PINS  = 3'd0,
    A_CEN   = 3'd1,
    A_CEVT  = 3'd2,
    A_DEN   = 3'd3,
    A_DEVT  = 3'd4,
    A_CAUSE = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_CARD = 2'd1,
    CAUSE_DMA  = 2'd2
  } cause_e;

  typedef struct packed {
    logic rem;
    logic ins;
    logic glb;
  } card_en_t;
endpackage

// File: rtl/cdi_sync.sv
module cdi_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdi_card_evt.sv
module cdi_card_evt
  import cdi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     present_s,
  input  logic     en_wr,
  input  card_en_t en_wdata,
  input  logic [1:0] evt_clr,
  output card_en_t en_q,
  output logic [1:0] evt_q,
  output logic     arm_ins,
  output logic     arm_rem,
  output logic     present_q,
  output logic     card_hit
);
  logic prev;
  logic set_ins, set_rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= present_s;
  end

  assign present_q = prev;
  assign arm_ins   = en_q.glb & en_q.ins & ~prev;
  assign arm_rem   = en_q.glb & en_q.rem &  prev;
  assign set_ins   = arm_ins &  present_s;
  assign set_rem   = arm_rem & ~present_s;
  assign card_hit  = set_ins | set_rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (card_hit) en_q <= '0;
    else if (en_wr)    en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr) | {set_rem, set_ins};
  end

  a_r5_ins_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[0]) |-> $past(arm_ins));
  a_r5_rem_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[1]) |-> $past(arm_rem));
  a_r6_enables_drop: assert property (@(posedge clk) disable iff (!rst_n)
    card_hit |=> (en_q == '0));
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr[0] && !set_ins) |=> !evt_q[0]);
endmodule

// File: rtl/cdi_dma_irq.sv
module cdi_dma_irq #(
  parameter int DMA_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DMA_W-1:0] evt,
  input  logic [DMA_W-1:0] evt_clr,
  input  logic             en_wr,
  input  logic [DMA_W-1:0] en_wdata,
  input  logic             kill,
  output logic [DMA_W-1:0] en_q,
  output logic [DMA_W-1:0] evt_q,
  output logic             pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (kill)  en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr) | evt;
  end

  assign pend = |(evt_q & en_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && evt_clr[0]) |=> evt_q[0]);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(evt_q & ~evt_clr)) == $past(evt_q & ~evt_clr)));
  a_r6_mask_drop: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (en_q == '0));
endmodule

// File: rtl/cdi_ctrl.sv
module cdi_ctrl
  import cdi_pkg::*;
#(
  parameter int DMA_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_present,
  input  logic             pin_wprot,
  input  logic             pin_busy,
  input  logic [DMA_W-1:0] dma_evt,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_s;
  card_en_t         cen_q;
  logic [1:0]       cevt_q;
  logic             arm_ins, arm_rem, present_q, card_hit;
  logic [DMA_W-1:0] den_q, devt_q;
  logic             dma_pend;
  logic             card_pend;
  cause_e           cause;

  logic wr_cen, wr_cevt, wr_den, wr_devt;
  assign wr_cen  = reg_wr && (reg_addr == A_CEN);
  assign wr_cevt = reg_wr && (reg_addr == A_CEVT);
  assign wr_den  = reg_wr && (reg_addr == A_DEN);
  assign wr_devt = reg_wr && (reg_addr == A_DEVT);

  cdi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pin_busy, pin_wprot, pin_present}),
    .q     (pins_s)
  );

  cdi_card_evt u_card (
    .clk       (clk),
    .rst_n     (rst_n),
    .present_s (pins_s[0]),
    .en_wr     (wr_cen),
    .en_wdata  (card_en_t'(reg_wdata[2:0])),
    .evt_clr   (wr_cevt ? reg_wdata[1:0] : 2'b00),
    .en_q      (cen_q),
    .evt_q     (cevt_q),
    .arm_ins   (arm_ins),
    .arm_rem   (arm_rem),
    .present_q (present_q),
    .card_hit  (card_hit)
  );

  cdi_dma_irq #(.DMA_W(DMA_W)) u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (dma_evt),
    .evt_clr  (wr_devt ? reg_wdata[DMA_W-1:0] : '0),
    .en_wr    (wr_den),
    .en_wdata (reg_wdata[DMA_W-1:0]),
    .kill     (card_hit),
    .en_q     (den_q),
    .evt_q    (devt_q),
    .pend     (dma_pend)
  );

  assign card_pend = |cevt_q;
  assign irq       = card_pend | dma_pend;

  always_comb begin
    if (card_pend)     cause = CAUSE_CARD;
    else if (dma_pend) cause = CAUSE_DMA;
    else               cause = CAUSE_NONE;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PINS:  reg_rdata[5:0] = {arm_rem, arm_ins, ~pins_s[2], pins_s[2], pins_s[1], pins_s[0]};
      A_CEN:   reg_rdata[2:0] = cen_q;
      A_CEVT:  reg_rdata[1:0] = cevt_q;
      A_DEN:   reg_rdata[DMA_W-1:0] = den_q;
      A_DEVT:  reg_rdata[DMA_W-1:0] = devt_q;
      A_CAUSE: reg_rdata[1:0] = cause;
      default: reg_rdata = '0;
    endcase
  end

  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
  a_r10_card_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CAUSE_CARD) |-> (irq && cevt_q != 2'b00));
  a_r5_edge_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (present_q == $past(pins_s[0])));
endmodule

// File: tb/sim_cdi_ctrl.sv
module sim_cdi_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;

  logic clk = 0, rst_n = 0;
  logic pin_present = 0, pin_wprot = 0, pin_busy = 0;
  logic [DW-1:0] dma_evt = '0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdi_ctrl #(.DMA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_present(pin_present), .pin_wprot(pin_wprot),
    .pin_busy(pin_busy), .dma_evt(dma_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin_present = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1, v); chk("R1 cen", v, 0);
    rd(2, v); chk("R1 cevt", v, 0);
    rd(3, v); chk("R1 den", v, 0);
    rd(4, v); chk("R1 devt", v, 0);
    chk("R1 irq", irq, 0);

    // R2 pin status sweep: 2 edges latency
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      pin_present = p[0]; pin_wprot = p[1]; pin_busy = p[2];
      @(negedge clk);
      rd(0, v); chk("R2 not yet", v[3:0], (p == 0) ? 4'b1000 : v[3:0]);
      @(negedge clk);
      rd(0, v); chk("R2 pins", v[3:0], {~p[2], p[2], p[1], p[0]});
    end
    @(negedge clk);
    pin_present = 0; pin_wprot = 0; pin_busy = 0;
    repeat (3) @(negedge clk);

    // R3..R6 card sweep: all enable patterns, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int en = 0; en < 8; en++) begin
        logic start, exp_hit, exp_ins, exp_rem;
        start = (dir == 1);            // dir 0 insert, dir 1 remove
        wr(1, 0);
        set_pin(start);
        wr(2, 8'h03);
        wr(3, 8'h07);
        wr(1, en[7:0]);
        rd(1, v); chk("R3 cen readback", v, en);
        rd(0, v);
        chk("R4 insert armed", v[4], en[0] & en[1] & ~start);
        chk("R4 remove armed", v[5], en[0] & en[2] & start);
        set_pin(~start);
        exp_ins = ~start & en[0] & en[1];
        exp_rem = start & en[0] & en[2];
        exp_hit = exp_ins | exp_rem;
        rd(2, v); chk("R5 card event", v, {exp_rem, exp_ins});
        rd(1, v); chk("R6 cen after", v, exp_hit ? 0 : en);
        rd(3, v); chk("R6 den after", v, exp_hit ? 0 : 7);
        chk("R9 irq card", irq, exp_hit);
        rd(5, v); chk("R10 cause card", v, exp_hit ? 1 : 0);
        if (exp_hit) begin
          wr(2, {6'b0, ~exp_rem, ~exp_ins});
          rd(2, v); chk("R7 write zero keeps", v, {exp_rem, exp_ins});
          wr(2, 8'h03);
          rd(2, v); chk("R7 w1c", v, 0);
          chk("R9 irq drop", irq, 0);
        end
      end
    end
    wr(1, 0);
    set_pin(0);
    wr(2, 8'h03);

    // R8..R10 DMA sweep
    for (int en = 0; en < 8; en++) begin
      for (int pat = 0; pat < 8; pat++) begin
        wr(3, en[7:0]);
        @(negedge clk); dma_evt = pat[DW-1:0];
        @(negedge clk); dma_evt = '0;
        rd(4, v); chk("R8 dma latch", v, pat);
        chk("R9 irq dma", irq, (pat & en) != 0);
        rd(5, v); chk("R10 cause dma", v, ((pat & en) != 0) ? 2 : 0);
        wr(4, pat[7:0]);
        rd(4, v); chk("R8 dma w1c", v, 0);
      end
    end

    // R8 set wins over clear
    @(negedge clk);
    reg_addr = 4; reg_wdata = 8'h01; reg_wr = 1; dma_evt = 3'b001;
    @(negedge clk);
    reg_wr = 0; dma_evt = '0;
    rd(4, v); chk("R8 set wins", v, 1);
    wr(4, 8'h07);

    // R10 card ranks above DMA, and card hit masks DMA
    wr(3, 8'h07);
    @(negedge clk); dma_evt = 3'b010;
    @(negedge clk); dma_evt = '0;
    wr(1, 8'h03);
    set_pin(1);
    rd(5, v); chk("R10 card first", v, 1);
    wr(2, 8'h03);
    rd(5, v); chk("R10 dma masked after card", v, 0);
    chk("R9 irq masked", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule